// File: doc/BRIEF.md
# Multi-Mode Timer Counter with Prescaler

This block is a single up/down counter that tracks elapsed time in units of a qualified tick. An incoming clock-enable pulse is first thinned by a power-of-two prescaler (divide by 1, 2, 4 or 8). Each surviving pulse advances the counter according to one of four modes: halted, up to a programmable period then back to zero, free-running over the full counter range, or a triangle that rises to the period and falls back to zero.

A clear strobe restarts the counter, the prescaler phase and the counting direction in one cycle. The strobe holds no state, so it always reads back as zero. Each time the count returns to zero through a wrap or a descent, a sticky overflow flag is set. That flag is gated by an enable onto an interrupt request. Two level indicators report when the count equals the period and when it equals zero. The block is meant to be driven by a register layer that lies outside it.

Top module: `modal_timer`

## Requirements
- R1: With mode code 00 (halt), the count, the direction and the prescaler phase hold whatever the tick input does.
- R2: With mode code 01 (up), each advance increments the count. An advance taken while the count is at or above the period loads zero and raises the overflow event instead, so the cycle is 0..period.
- R3: With mode code 10 (free), each advance increments the count. An advance at all-ones loads zero and raises the overflow event.
- R4: With mode code 11 (up/down), the count rises to the period and then falls to zero, repeating. `dir_down_o` is 1 from the advance that reaches the period until the advance that reaches zero. Reaching zero raises the overflow event.
- R5: Divider code 00, 01, 10 or 11 produces one advance for every 1, 2, 4 or 8 cycles with the tick input high. After a clear, the Nth qualifying tick of a group produces the advance.
- R6: A clear strobe loads count zero, direction up and prescaler phase zero in the next cycle. It takes priority over an advance in the same cycle.
- R7: `irq_o` is high exactly when the overflow flag and `irq_en` are both high.
- R8: The overflow flag sets on an overflow event and stays set until `flag_clr` is pulsed. A set and a clear in the same cycle leave it set. The clear strobe does not touch it.
- R9: The count changes only on an advance or a clear. Changing the mode does not alter the count.
- R10: `at_period_o` is high while the count equals `period`, and `at_zero_o` is high while the count is zero.
- R11: After reset, the count is zero, the direction is up, and the flag and the interrupt request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Input tick (clock enable) before division |
| mode_sel | input | 2 | 00 halt, 01 up, 10 free, 11 up/down |
| div_sel | input | 2 | Prescaler select: divide by 1, 2, 4, 8 |
| period | input | CNT_W | Period / turn-around value |
| clear_pulse | input | 1 | Restart count, prescaler and direction |
| irq_en | input | 1 | Interrupt enable for the overflow flag |
| flag_clr | input | 1 | Clears the overflow flag |
| count_o | output | CNT_W | Current count |
| dir_down_o | output | 1 | 1 while counting down |
| at_period_o | output | 1 | Count equals period |
| at_zero_o | output | 1 | Count equals zero |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The bound checker watches, on every cycle, the local rules that one edge can expose. These are: the hold in halt mode, the stillness without an advance, the clear result, the increment and rollover in free mode, the turn at the bottom in up/down mode, the spacing of advances with a divider, flag stickiness and interrupt masking. Only the bench scenarios can show whole sequences. Those include the exact count after N ticks for each mode and divider, the full turn-around shape of the triangle, the prescaler phase restart after a mid-group clear, preservation of the count across mode changes, and the set-over-clear priority of the flag.

// File: rtl/modal_timer_pkg.sv
package modal_timer_pkg;

    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_UP   = 2'b01,
        MODE_FREE = 2'b10,
        MODE_UPDN = 2'b11
    } tmr_mode_e;

endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             adv
);
    localparam int PS_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PS_W-1:0] phase;
    } ps_state_t;

    ps_state_t       st_d, st_q;
    logic [PS_W-1:0] lim;
    logic            last;

    always_comb begin
        lim  = PS_W'((1 << div_sel) - 1);
        last = (st_q.phase >= lim);
        adv  = tick_en && run && !restart && last;
        st_d = st_q;
        if (restart) begin
            st_d.phase = '0;
        end else if (tick_en && run) begin
            st_d.phase = last ? '0 : st_q.phase + PS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/mt_count_core.sv
module mt_count_core
    import modal_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clear,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] inc, dec;

    always_comb begin
        inc      = st_q.cnt + CNT_W'(1);
        dec      = st_q.cnt - CNT_W'(1);
        st_d     = st_q;
        wrap_evt = 1'b0;
        if (clear) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (adv) begin
            unique case (mode)
                MODE_HALT: ;
                MODE_UP: begin
                    st_d.down = 1'b0;
                    if (st_q.cnt >= period) begin
                        st_d.cnt = '0;
                        wrap_evt = 1'b1;
                    end else begin
                        st_d.cnt = inc;
                    end
                end
                MODE_FREE: begin
                    st_d.down = 1'b0;
                    st_d.cnt  = inc;
                    wrap_evt  = (st_q.cnt == CNT_MAX);
                end
                MODE_UPDN: begin
                    if (st_q.down || (st_q.cnt >= period && st_q.cnt != '0)) begin
                        if (st_q.cnt <= CNT_W'(1)) begin
                            st_d.cnt  = '0;
                            st_d.down = 1'b0;
                            wrap_evt  = 1'b1;
                        end else begin
                            st_d.cnt  = dec;
                            st_d.down = 1'b1;
                        end
                    end else if (st_q.cnt < period) begin
                        st_d.cnt  = inc;
                        st_d.down = (inc == period);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.cnt;
    assign dir_down = st_q.down;

endmodule

// File: rtl/mt_ovf_flag.sv
module mt_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_evt)  st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & irq_en;

endmodule

// File: rtl/modal_timer.sv
module modal_timer
    import modal_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [1:0]       mode_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [CNT_W-1:0] period,
    input  logic             clear_pulse,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_down_o,
    output logic             at_period_o,
    output logic             at_zero_o,
    output logic             ovf_flag_o,
    output logic             irq_o
);
    tmr_mode_e mode;
    logic      run;
    logic      adv;
    logic      wrap_evt;

    assign mode = tmr_mode_e'(mode_sel);
    assign run  = (mode != MODE_HALT);

    mt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (run),
        .restart (clear_pulse),
        .div_sel (div_sel),
        .adv     (adv)
    );

    mt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .clear    (clear_pulse),
        .mode     (mode),
        .period   (period),
        .count    (count_o),
        .dir_down (dir_down_o),
        .wrap_evt (wrap_evt)
    );

    mt_ovf_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (wrap_evt),
        .clr     (flag_clr),
        .irq_en  (irq_en),
        .flag    (ovf_flag_o),
        .irq     (irq_o)
    );

    assign at_period_o = (count_o == period);
    assign at_zero_o   = (count_o == '0);

endmodule

// File: rtl/modal_timer_chk.sv
module modal_timer_chk #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic [DIV_W-1:0] div_sel,
    input logic             clear_pulse,
    input logic             flag_clr,
    input logic             irq_en,
    input logic             adv,
    input logic [CNT_W-1:0] count_o,
    input logic             dir_down_o,
    input logic             ovf_flag_o,
    input logic             irq_o
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && !clear_pulse) |=> $stable(count_o) && $stable(dir_down_o)); // R1
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && adv && !clear_pulse) |=> count_o == CNT_W'($past(count_o) + CNT_W'(1))); // R3
    AST_UPDN_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11 && adv && !clear_pulse && dir_down_o && count_o == CNT_W'(1))
        |=> (count_o == '0 && !dir_down_o && ovf_flag_o)); // R4
    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && div_sel != '0) |=> (!adv || div_sel == '0)); // R5
    AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> (count_o == '0 && !dir_down_o)); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !flag_clr) |=> ovf_flag_o); // R8
    AST_NO_ADV_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clear_pulse) |=> $stable(count_o)); // R9
endmodule

bind modal_timer modal_timer_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .div_sel     (div_sel),
    .clear_pulse (clear_pulse),
    .flag_clr    (flag_clr),
    .irq_en      (irq_en),
    .adv         (adv),
    .count_o     (count_o),
    .dir_down_o  (dir_down_o),
    .ovf_flag_o  (ovf_flag_o),
    .irq_o       (irq_o)
);

// File: tb/modal_timer_bench.sv
module modal_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  div;
        logic [15:0] per;
        logic [15:0] n;
        logic [15:0] cnt;
        logic        dir;
        logic        flag;
        logic [7:0]  req;
    } vec_t;

    // mode, div, period, ticks, expected count, dir, flag, requirement number
    localparam vec_t VECS [NV] = '{
        '{2'b01, 2'd0, 16'd5,   16'd4,  16'd4, 1'b0, 1'b0, 8'd2},  // R2
        '{2'b01, 2'd0, 16'd5,   16'd6,  16'd0, 1'b0, 1'b1, 8'd2},  // R2 wrap
        '{2'b01, 2'd0, 16'd5,   16'd8,  16'd2, 1'b0, 1'b1, 8'd2},  // R2
        '{2'b01, 2'd0, 16'd0,   16'd3,  16'd0, 1'b0, 1'b1, 8'd2},  // R2 zero period
        '{2'b10, 2'd0, 16'd5,   16'd10, 16'd10, 1'b0, 1'b0, 8'd3}, // R3
        '{2'b11, 2'd0, 16'd3,   16'd3,  16'd3, 1'b1, 1'b0, 8'd4},  // R4 top
        '{2'b11, 2'd0, 16'd3,   16'd5,  16'd1, 1'b1, 1'b0, 8'd4},  // R4 falling
        '{2'b11, 2'd0, 16'd3,   16'd6,  16'd0, 1'b0, 1'b1, 8'd4},  // R4 bottom
        '{2'b11, 2'd0, 16'd3,   16'd7,  16'd1, 1'b0, 1'b1, 8'd4},  // R4 rising again
        '{2'b01, 2'd1, 16'd100, 16'd9,  16'd4, 1'b0, 1'b0, 8'd5},  // R5 /2
        '{2'b01, 2'd2, 16'd100, 16'd17, 16'd4, 1'b0, 1'b0, 8'd5},  // R5 /4
        '{2'b01, 2'd3, 16'd100, 16'd33, 16'd4, 1'b0, 1'b0, 8'd5},  // R5 /8
        '{2'b00, 2'd0, 16'd5,   16'd10, 16'd0, 1'b0, 1'b0, 8'd1}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [1:0]  div_sel = 2'b00;
    logic [15:0] period = '0;
    logic        clear_pulse = 1'b0;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] count_o;
    logic        dir_down_o, at_period_o, at_zero_o, ovf_flag_o, irq_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modal_timer u_modal_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
        .div_sel(div_sel), .period(period), .clear_pulse(clear_pulse),
        .irq_en(irq_en), .flag_clr(flag_clr), .count_o(count_o),
        .dir_down_o(dir_down_o), .at_period_o(at_period_o), .at_zero_o(at_zero_o),
        .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_pulse = 1'b1;
        flag_clr    = 1'b1;
        @(negedge clk);
        clear_pulse = 1'b0;
        flag_clr    = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "count", 32'(count_o), 32'd0);
        check("R11", "dir", 32'(dir_down_o), 32'd0);
        check("R11", "flag", 32'(ovf_flag_o), 32'd0);
        check("R11", "irq", 32'(irq_o), 32'd0);

        for (int v = 0; v < NV; v++) begin
            mode_sel = VECS[v].mode;
            div_sel  = VECS[v].div;
            period   = VECS[v].per;
            do_clear();
            run_ticks(int'(VECS[v].n));
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d count", v), 32'(count_o), 32'(VECS[v].cnt));
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d dir", v), 32'(dir_down_o), 32'(VECS[v].dir));
            check($sformatf("R%0d", VECS[v].req), $sformatf("vec%0d flag", v), 32'(ovf_flag_o), 32'(VECS[v].flag));
            // R10 equality indicators
            check("R10", $sformatf("vec%0d at_zero", v), 32'(at_zero_o), 32'(VECS[v].cnt == 16'd0));
            check("R10", $sformatf("vec%0d at_period", v), 32'(at_period_o), 32'(VECS[v].cnt == VECS[v].per));
        end

        // R1 / R9: mode changes keep the count, no tick means no motion
        mode_sel = 2'b01; div_sel = 2'd0; period = 16'd100;
        do_clear();
        run_ticks(7);
        check("R9", "up count", 32'(count_o), 32'd7);
        mode_sel = 2'b00;
        run_ticks(5);
        check("R1", "halt hold", 32'(count_o), 32'd7);
        mode_sel = 2'b10;
        repeat (4) @(negedge clk);
        check("R9", "idle hold", 32'(count_o), 32'd7);
        run_ticks(3);
        check("R9", "free resume", 32'(count_o), 32'd10);

        // R6: clear restarts the prescaler phase and the direction
        mode_sel = 2'b01; div_sel = 2'd2; period = 16'd100;
        do_clear();
        run_ticks(6);
        check("R5", "div4 six ticks", 32'(count_o), 32'd1);
        do_clear();
        check("R6", "clear count", 32'(count_o), 32'd0);
        run_ticks(3);
        check("R6", "phase restart 3", 32'(count_o), 32'd0);
        run_ticks(1);
        check("R6", "phase restart 4", 32'(count_o), 32'd1);
        mode_sel = 2'b11; div_sel = 2'd0; period = 16'd3;
        do_clear();
        run_ticks(4);
        check("R4", "falling dir", 32'(dir_down_o), 32'd1);
        do_clear();
        check("R6", "clear dir", 32'(dir_down_o), 32'd0);
        check("R6", "clear count ud", 32'(count_o), 32'd0);

        // R7 / R8: flag gating, stickiness, priority
        mode_sel = 2'b01; div_sel = 2'd0; period = 16'd2; irq_en = 1'b0;
        do_clear();
        run_ticks(3);
        check("R8", "flag set", 32'(ovf_flag_o), 32'd1);
        check("R7", "irq masked", 32'(irq_o), 32'd0);
        irq_en = 1'b1;
        #1;
        check("R7", "irq enabled", 32'(irq_o), 32'd1);
        run_ticks(2);
        check("R8", "flag sticky", 32'(ovf_flag_o), 32'd1);
        @(negedge clk);
        clear_pulse = 1'b1;
        @(negedge clk);
        clear_pulse = 1'b0;
        check("R8", "strobe keeps flag", 32'(ovf_flag_o), 32'd1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R8", "flag cleared", 32'(ovf_flag_o), 32'd0);
        check("R7", "irq dropped", 32'(irq_o), 32'd0);
        run_ticks(2);
        check("R2", "at period", 32'(count_o), 32'd2);
        @(negedge clk);
        tick_en = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; flag_clr = 1'b0;
        check("R8", "set wins", 32'(ovf_flag_o), 32'd1);
        irq_en = 1'b0;

        // R3: full range rollover
        mode_sel = 2'b10; div_sel = 2'd0;
        do_clear();
        run_ticks(65535);
        check("R3", "all ones", 32'(count_o), 32'hFFFF);
        check("R3", "no flag yet", 32'(ovf_flag_o), 32'd0);
        run_ticks(1);
        check("R3", "rollover count", 32'(count_o), 32'd0);
        check("R3", "rollover flag", 32'(ovf_flag_o), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule